// File: doc/BRIEF.md
# Injection Flood Guard with Port Blocking

This block guards the links that carry frames from each processor into its local router in a small mesh. For every local port it follows the stream of frames the processor injects and measures the length of the current run, meaning how many sends in a row have gone to the same destination. When that run grows past a programmable limit, the port is treated as compromised. An attack flag is raised for that port and every later injection from it is suppressed before it reaches the router.

Traffic that the router carries for other routers has a separate transit valid path. That path passes through unchanged whether or not the local port is blocked. The flag stays set until the port's clear input is pulsed. A count of blocked ports is provided for system-level shutdown logic, together with a shutdown indication that is raised as soon as two or more ports are blocked.

Top module: `inject_guard`

## Requirements
- R1: After reset, every attack flag is low, the blocked count is 0 and shutdown is low, so injections pass unchanged.
- R2: A send to the same destination as the previous counted send extends the run by one. A send to a different destination starts a new run of length 1 aimed at that destination. Idle cycles do not break a run.
- R3: With limit value r, the attack flag rises one clock after the send that makes the run length exceed r, which is the (r+1)th consecutive same-destination send. That send itself is still forwarded. A limit of 0 therefore flags on the first send.
- R4: While a port's attack flag is high, that port's forwarded injection valid is low in every cycle.
- R5: The attack flag stays high until the port's clear is pulsed. Sends made while blocked are not counted.
- R6: A clear pulse drops the flag one clock later and empties the run. A send presented in the same cycle as the clear is not counted, and it is dropped if the port was blocked.
- R7: The run counter saturates at its maximum and never wraps. A limit equal to the counter's maximum (all ones, 15 with the default width) never raises the flag.
- R8: Each transit valid output equals its transit valid input in the same cycle, regardless of any attack flag.
- R9: The blocked count equals the number of ports whose flag is high, and shutdown is high exactly when that count is 2 or more.
- R10: Ports are independent: a send, clear or block on one port never changes another port's flag or forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_limit | input | RUN_W | Run-length limit r shared by all ports |
| inj_valid | input | NUM_PORTS | Processor injection valid, one bit per port |
| inj_dest | input | NUM_PORTS*DEST_W | Destination ID per port; port i uses bits [i*DEST_W +: DEST_W] |
| inj_clear | input | NUM_PORTS | Per-port pulse that clears the attack flag and the run |
| transit_valid_in | input | NUM_PORTS | Valid of frames forwarded for other routers |
| inj_valid_out | output | NUM_PORTS | Injection valid after blocking |
| transit_valid_out | output | NUM_PORTS | Transit valid, passed through |
| attack_flag | output | NUM_PORTS | Sticky per-port attack flag |
| blocked_count | output | CNT_W | Number of ports currently blocked |
| shutdown | output | 1 | High when two or more ports are blocked |

## Verification
Forwarding and transit valids are combinational. The bench drives on the falling edge and samples them 1 ns later, inside the same cycle. Attack flags, the blocked count and shutdown change on the rising edge that samples the triggering send or clear, so they are checked at the next falling edge, one full cycle after the stimulus. Run-length effects such as gaps that do not break a run, restarts on a new destination, and clears that must not count a send are checked by the cycle in which the flag first appears, not only by whether it appears.

// File: rtl/inject_guard_pkg.sv
// Shared types for the injection flood guard.
// Assumes nothing beyond a synchronous design context.
package inject_guard_pkg;

    // Tracker state: no run yet, run in progress, port blocked
    typedef enum logic [1:0] {
        TRK_IDLE    = 2'd0,
        TRK_RUN     = 2'd1,
        TRK_BLOCKED = 2'd2
    } trk_state_t;

endpackage

// File: rtl/inject_run_tracker.sv
// Per-port run-length tracker. It counts consecutive sends to the same
// destination and latches a blocked state when the run exceeds the limit.
// Assumes: one frame per cycle at most; clear has priority over sends.
module inject_run_tracker
    import inject_guard_pkg::*;
#(
    parameter int DEST_W = 2,
    parameter int RUN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send,
    input  logic [DEST_W-1:0] dest,
    input  logic              clear,
    input  logic [RUN_W-1:0]  limit,
    output logic              blocked
);

    localparam logic [RUN_W-1:0] RUN_MAX = '1;
    localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

    trk_state_t        state_q, state_d;
    logic [RUN_W-1:0]  run_q, run_d;
    logic [DEST_W-1:0] target_q, target_d;
    logic [RUN_W-1:0]  run_next;

    // Length the run would have if this cycle's send is counted
    always_comb begin
        if (state_q == TRK_RUN && dest == target_q)
            run_next = (run_q == RUN_MAX) ? run_q : run_q + RUN_ONE;
        else
            run_next = RUN_ONE;
    end

    // Next-state logic: clear, then counting, then block decision
    always_comb begin
        state_d  = state_q;
        run_d    = run_q;
        target_d = target_q;
        if (clear) begin
            state_d = TRK_IDLE;
            run_d   = '0;
        end else if (send && state_q != TRK_BLOCKED) begin
            run_d    = run_next;
            target_d = dest;
            state_d  = (run_next > limit) ? TRK_BLOCKED : TRK_RUN;
        end
    end

    // State registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TRK_IDLE;
            run_q    <= '0;
            target_q <= '0;
        end else begin
            state_q  <= state_d;
            run_q    <= run_d;
            target_q <= target_d;
        end
    end

    assign blocked = (state_q == TRK_BLOCKED);

endmodule

// File: rtl/inject_block_counter.sv
// Counts blocked ports and raises a shutdown indication at two or more.
// Assumes: flag vector is registered upstream; output is combinational.
module inject_block_counter #(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = $clog2(NUM_PORTS + 1)
) (
    input  logic [NUM_PORTS-1:0] flags,
    output logic [CNT_W-1:0]     count,
    output logic                 shutdown
);

    localparam logic [CNT_W-1:0] SHUT_AT = CNT_W'(2);

    // Population count of the flag vector
    always_comb begin
        count = '0;
        for (int i = 0; i < NUM_PORTS; i++)
            count = count + CNT_W'(flags[i]);
    end

    assign shutdown = (count >= SHUT_AT);

endmodule

// File: rtl/inject_guard.sv
// Top of the injection flood guard: one run tracker per local port, gating
// of injections from blocked ports, transit pass-through and shutdown count.
// Assumes: destinations are packed per port in inj_dest; limit is shared.
module inject_guard #(
    parameter int NUM_PORTS = 4,
    parameter int DEST_W    = 2,
    parameter int RUN_W     = 4,
    parameter int CNT_W     = $clog2(NUM_PORTS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [RUN_W-1:0]            run_limit,
    input  logic [NUM_PORTS-1:0]        inj_valid,
    input  logic [NUM_PORTS*DEST_W-1:0] inj_dest,
    input  logic [NUM_PORTS-1:0]        inj_clear,
    input  logic [NUM_PORTS-1:0]        transit_valid_in,
    output logic [NUM_PORTS-1:0]        inj_valid_out,
    output logic [NUM_PORTS-1:0]        transit_valid_out,
    output logic [NUM_PORTS-1:0]        attack_flag,
    output logic [CNT_W-1:0]            blocked_count,
    output logic                        shutdown
);

    logic [NUM_PORTS-1:0] blocked;

    // One tracker and one gate per local port
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        inject_run_tracker #(
            .DEST_W (DEST_W),
            .RUN_W  (RUN_W)
        ) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .send    (inj_valid[p]),
            .dest    (inj_dest[p*DEST_W +: DEST_W]),
            .clear   (inj_clear[p]),
            .limit   (run_limit),
            .blocked (blocked[p])
        );
        assign inj_valid_out[p] = inj_valid[p] & ~blocked[p];
    end

    assign attack_flag       = blocked;
    assign transit_valid_out = transit_valid_in;

    inject_block_counter #(
        .NUM_PORTS (NUM_PORTS),
        .CNT_W     (CNT_W)
    ) u_cnt (
        .flags    (blocked),
        .count    (blocked_count),
        .shutdown (shutdown)
    );

endmodule

// File: rtl/inject_guard_checker.sv
// Assertion checker for the injection flood guard, bound to the top.
// Assumes: same parameters as the bound instance.
module inject_guard_checker #(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] inj_valid,
    input logic [NUM_PORTS-1:0] inj_clear,
    input logic [NUM_PORTS-1:0] inj_valid_out,
    input logic [NUM_PORTS-1:0] attack_flag,
    input logic [CNT_W-1:0]     blocked_count,
    input logic                 shutdown
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R4: a blocked port forwards nothing
        p_no_fwd_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
            attack_flag[p] |-> !inj_valid_out[p]);
        // R5: flag holds until cleared
        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (attack_flag[p] && !inj_clear[p]) |=> attack_flag[p]);
        // R6: clear drops the flag next cycle
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            inj_clear[p] |=> !attack_flag[p]);
        // R3: a flag only rises after a forwarded send
        p_rise_after_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(attack_flag[p]) |-> $past(inj_valid_out[p]));
    end

    // R9: shutdown needs at least two flagged ports
    p_shutdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> ($countones(attack_flag) >= 2));
    // R9: count matches the flag vector
    p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(blocked_count) == $countones(attack_flag));

endmodule

bind inject_guard inject_guard_checker #(
    .NUM_PORTS (NUM_PORTS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inj_valid     (inj_valid),
    .inj_clear     (inj_clear),
    .inj_valid_out (inj_valid_out),
    .attack_flag   (attack_flag),
    .blocked_count (blocked_count),
    .shutdown      (shutdown)
);

// File: tb/inject_guard_test.sv
// Self-checking bench: vector table on port 0, then directed tests.
module inject_guard_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 2;
    localparam int RW = 4;
    localparam int CW = 3;
    localparam int NVEC = 22;

    // Row: {valid, dest[1:0], clear, limit[3:0], exp_fwd, exp_flag_next}
    localparam logic [9:0] VEC [NVEC] = '{
        10'b1_01_0_0011_1_0,  // R2 run=1 dest1
        10'b1_01_0_0011_1_0,  // R2 run=2
        10'b1_10_0_0011_1_0,  // R2 new dest restarts run=1
        10'b1_10_0_0011_1_0,  // run=2
        10'b0_00_0_0011_0_0,  // R2 idle keeps run
        10'b1_10_0_0011_1_0,  // run=3
        10'b1_10_0_0011_1_1,  // R3 run=4>3, forwarded, flag next
        10'b1_10_0_0011_0_1,  // R4 blocked
        10'b1_11_0_0011_0_1,  // R5 blocked, not counted
        10'b0_00_1_0011_0_0,  // R6 clear
        10'b1_11_0_0011_1_0,  // run=1
        10'b1_11_0_0011_1_0,
        10'b1_11_0_0011_1_0,
        10'b1_11_0_0011_1_1,  // R3 run=4
        10'b1_11_1_0011_0_0,  // R6 clear with send: dropped, not counted
        10'b1_11_0_0011_1_0,  // run=1
        10'b1_11_0_0011_1_0,
        10'b1_11_0_0011_1_0,
        10'b1_11_0_0011_1_1,  // R6 flag exactly at 4th send
        10'b0_00_1_0000_0_0,  // clear, limit 0
        10'b1_01_0_0000_1_1,  // R3 limit 0 flags on first send
        10'b0_00_1_0000_0_0   // clear
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RW-1:0]     run_limit = '0;
    logic [NP-1:0]     inj_valid = '0;
    logic [NP*DW-1:0]  inj_dest = '0;
    logic [NP-1:0]     inj_clear = '0;
    logic [NP-1:0]     transit_valid_in = '0;
    logic [NP-1:0]     inj_valid_out;
    logic [NP-1:0]     transit_valid_out;
    logic [NP-1:0]     attack_flag;
    logic [CW-1:0]     blocked_count;
    logic              shutdown;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    inject_guard #(.NUM_PORTS(NP), .DEST_W(DW), .RUN_W(RW), .CNT_W(CW)) uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .run_limit         (run_limit),
        .inj_valid         (inj_valid),
        .inj_dest          (inj_dest),
        .inj_clear         (inj_clear),
        .transit_valid_in  (transit_valid_in),
        .inj_valid_out     (inj_valid_out),
        .transit_valid_out (transit_valid_out),
        .attack_flag       (attack_flag),
        .blocked_count     (blocked_count),
        .shutdown          (shutdown)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Send once on port p (drive at negedge, sample after the next negedge)
    task automatic send(input int p, input int d);
        @(negedge clk);
        inj_valid = '0;
        inj_clear = '0;
        inj_valid[p] = 1'b1;
        inj_dest[p*DW +: DW] = DW'(d);
        @(negedge clk);
        inj_valid = '0;
    endtask

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(attack_flag == '0, "R1 flags", int'(attack_flag), 0);
        check(blocked_count == '0, "R1 count", int'(blocked_count), 0);
        check(shutdown == 1'b0, "R1 shutdown", int'(shutdown), 0);
        inj_valid[0] = 1'b1;
        #1;
        check(inj_valid_out[0] == 1'b1, "R1 pass", int'(inj_valid_out[0]), 1);
        inj_valid = '0;

        // Vector table on port 0
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            inj_valid[0]   = VEC[k][9];
            inj_dest[1:0]  = VEC[k][8:7];
            inj_clear[0]   = VEC[k][6];
            run_limit      = VEC[k][5:2];
            #1;
            check(inj_valid_out[0] == VEC[k][1], $sformatf("R4 fwd row %0d", k),
                  int'(inj_valid_out[0]), int'(VEC[k][1]));
            @(negedge clk);
            check(attack_flag[0] == VEC[k][0], $sformatf("R3 R5 R6 flag row %0d", k),
                  int'(attack_flag[0]), int'(VEC[k][0]));
            inj_valid = '0;
            inj_clear = '0;
        end

        // R7 saturation: limit all ones never flags
        run_limit = 4'hF;
        for (int k = 0; k < 20; k++) send(0, 2);
        check(attack_flag[0] == 1'b0, "R7 saturate", int'(attack_flag[0]), 0);

        // R9 R10 two ports blocked
        run_limit = 4'd1;
        send(1, 0);
        send(1, 0);
        check(attack_flag[1] == 1'b1, "R3 port1 flag", int'(attack_flag[1]), 1);
        check(attack_flag[0] == 1'b0, "R10 port0 untouched", int'(attack_flag[0]), 0);
        check(blocked_count == 3'd1, "R9 count one", int'(blocked_count), 1);
        check(shutdown == 1'b0, "R9 no shutdown", int'(shutdown), 0);
        send(2, 3);
        send(2, 3);
        check(blocked_count == 3'd2, "R9 count two", int'(blocked_count), 2);
        check(shutdown == 1'b1, "R9 shutdown", int'(shutdown), 1);

        // R8 transit passes while blocked; R10 port 3 still forwards
        @(negedge clk);
        transit_valid_in = '1;
        inj_valid = 4'b1110;
        #1;
        check(transit_valid_out == 4'b1111, "R8 transit", int'(transit_valid_out), 15);
        check(inj_valid_out == 4'b1000, "R10 gate", int'(inj_valid_out), 8);
        transit_valid_in = 4'b0101;
        #1;
        check(transit_valid_out == 4'b0101, "R8 transit pattern", int'(transit_valid_out), 5);
        @(negedge clk);
        inj_valid = '0;
        transit_valid_in = '0;
        inj_clear = 4'b0010;
        @(negedge clk);
        inj_clear = '0;
        check(attack_flag == 4'b0100, "R6 R10 clear one port", int'(attack_flag), 4);
        check(shutdown == 1'b0, "R9 shutdown drops", int'(shutdown), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule